// File: doc/BRIEF.md
# Lazily Word-Filled Data Filter Cache

This block is a tiny data cache placed between a core's load/store stage and its level-one data cache. It holds 512 bytes as 16 lines of eight 32-bit words. It never brings in a whole line on a miss. Only the word that a load actually touches is fetched from the level-one cache and written into the filter cache. Every word slot keeps its own valid bit and its own source tag. As a result, one filter line can carry words that came from several different level-one lines.

The core gives a speculative word address one cycle ahead of the real request. The block runs its tag search on that early address and registers the result. When the real request arrives with the same word address and the early search found the word, the data array is read and the load is answered on the next cycle without touching the level-one cache. In every other case the request goes to the level-one port in the same cycle it arrives. Stores always write through to the level-one cache. Lines are replaced in least-recently-used order.

Address layout used throughout: byte offset `addr[1:0]`, word slot `addr[4:2]`, source tag `addr[31:5]`. The speculative port carries `addr[31:2]`.

Top module: `fc_lazy_filter_cache`

## Requirements
- R1: After reset no word is valid, `req_ready` is 1, both counters read 0, and the first load of any address goes to the level-one port even when the early address matches it.
- R2: A load that is not a guaranteed hit issues exactly one level-one read of that word. The block returns the level-one data on `rsp_rdata` with `rsp_valid` one cycle after `l1_rsp_valid`, and it marks that single word valid.
- R3: A load of an uncached word whose level-one line already has other words cached is a word miss. It fetches only that word, and the words already cached stay hits.
- R4: Words from different level-one lines share a filter line. A word slot is placed by priority: the slot that already holds the word, then a line that already holds a word from the same level-one line, then the lowest-numbered line whose slot for that word offset is empty, then the LRU victim. No word is ever held twice.
- R5: When `spec_valid` was 1 in the cycle before a load, `spec_waddr` equals `req_addr[31:2]`, and that word is valid, the load is answered one cycle later from the data array with no level-one request.
- R6: A load without an early address, or whose early word address differs from the final one, goes to the level-one port in the same cycle it is presented, even if the word is cached.
- R7: Every store issues one level-one write in the cycle it is accepted. A store to a valid word also updates the cached copy. A store to an uncached word allocates nothing. The store completes one cycle after the level-one acknowledge.
- R8: When no empty slot or same-source line exists for a fill, the least recently used line (loads that hit and fills both count as use) is evicted, and all of its word valid bits are cleared before the new word is written.
- R9: `hit_count` increments once per guaranteed hit, and `fill_count` increments once per completed level-one read.
- R10: While a level-one transaction is outstanding, `req_ready` is 0 and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_valid | input | 1 | Early word address is valid this cycle |
| spec_waddr | input | 30 | Early word address (address bits 31:2) |
| req_valid | input | 1 | Load/store request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Load data (0 for stores) |
| l1_req_valid | output | 1 | Level-one request |
| l1_req_write | output | 1 | Level-one request is a write |
| l1_req_addr | output | 32 | Level-one request address |
| l1_req_wdata | output | 32 | Level-one write data |
| l1_rsp_valid | input | 1 | Level-one response or write acknowledge |
| l1_rsp_rdata | input | 32 | Level-one read data |
| hit_count | output | 16 | Guaranteed-hit counter |
| fill_count | output | 16 | Word-fill counter |

## Verification
The assertions assume that the level-one side answers each issued request with exactly one `l1_rsp_valid` pulse and raises it at no other time. They also assume that `req_valid` is only sampled as meaningful while `req_ready` is high. The bench's level-one model answers every request once, one cycle after it is accepted. The bench drives one request at a time and waits for its response before the next, and it presents the early address only in the cycle just before a request. Under these conditions the single-copy, single-valid-after-eviction and counter properties describe all legal traffic.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {
    FC_IDLE = 1'b0,
    FC_WAIT = 1'b1
  } fc_state_e;
endpackage

// File: rtl/fc_word_lookup.sv
module fc_word_lookup #(
  parameter int LINES = 16,
  parameter int WORDS = 8,
  parameter int TAG_W = 27
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [TAG_W-1:0]                      tag_i,
  input  logic [$clog2(WORDS)-1:0]              word_i,
  input  logic [LINES-1:0][WORDS-1:0]           valid_i,
  input  logic [LINES-1:0][WORDS-1:0][TAG_W-1:0] tags_i,
  output logic                                  hit_o,
  output logic [$clog2(LINES)-1:0]              hit_line_o
);
  localparam int LINE_W = $clog2(LINES);

  logic [LINES-1:0] hit_vec;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign hit_vec[l] = valid_i[l][word_i] && (tags_i[l][word_i] == tag_i);
  end

  always_comb begin
    hit_line_o = '0;
    for (int l = LINES - 1; l >= 0; l--) begin
      if (hit_vec[l]) hit_line_o = LINE_W'(l);
    end
  end

  assign hit_o = |hit_vec;

  // a word is never held in two slots
  assert_single_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/fc_fill_place.sv
module fc_fill_place #(
  parameter int LINES = 16,
  parameter int WORDS = 8,
  parameter int TAG_W = 27
) (
  input  logic [TAG_W-1:0]                       tag_i,
  input  logic [$clog2(WORDS)-1:0]               word_i,
  input  logic [LINES-1:0][WORDS-1:0]            valid_i,
  input  logic [LINES-1:0][WORDS-1:0][TAG_W-1:0] tags_i,
  input  logic                                   hit_i,
  input  logic [$clog2(LINES)-1:0]               hit_line_i,
  input  logic [$clog2(LINES)-1:0]               victim_i,
  output logic [$clog2(LINES)-1:0]               line_o,
  output logic                                   evict_o
);
  localparam int LINE_W = $clog2(LINES);

  logic [LINES-1:0][WORDS-1:0] same_src;
  logic [LINES-1:0]            home_vec;
  logic [LINES-1:0]            free_vec;
  logic [LINE_W-1:0]           home_line;
  logic [LINE_W-1:0]           free_line;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign same_src[l][w] = valid_i[l][w] && (tags_i[l][w] == tag_i);
    end
    assign home_vec[l] = |same_src[l];
    assign free_vec[l] = !valid_i[l][word_i];
  end

  always_comb begin
    home_line = '0;
    free_line = '0;
    for (int l = LINES - 1; l >= 0; l--) begin
      if (home_vec[l]) home_line = LINE_W'(l);
      if (free_vec[l]) free_line = LINE_W'(l);
    end
  end

  always_comb begin
    evict_o = 1'b0;
    if (hit_i)            line_o = hit_line_i;
    else if (|home_vec)   line_o = home_line;
    else if (|free_vec)   line_o = free_line;
    else begin
      line_o  = victim_i;
      evict_o = 1'b1;
    end
  end
endmodule

// File: rtl/fc_lru.sv
module fc_lru #(
  parameter int LINES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_i,
  input  logic [$clog2(LINES)-1:0] touch_line_i,
  output logic [$clog2(LINES)-1:0] victim_o
);
  localparam int LINE_W = $clog2(LINES);
  localparam logic [LINE_W-1:0] OLDEST = LINE_W'(LINES - 1);

  logic [LINES-1:0][LINE_W-1:0] age_q;
  logic [LINES-1:0]             oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= LINE_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < LINES; i++) begin
        if (LINE_W'(i) == touch_line_i)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_line_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_old
    assign oldest_vec[i] = (age_q[i] == OLDEST);
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (oldest_vec[i]) victim_o = LINE_W'(i);
    end
  end

  // ages stay a permutation: exactly one line is oldest
  assert_one_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/fc_line_store.sv
module fc_line_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 27,
  parameter int DATA_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   data_we,
  input  logic                                   alloc_en,
  input  logic                                   alloc_evict,
  input  logic [$clog2(LINES)-1:0]               line_i,
  input  logic [$clog2(WORDS)-1:0]               word_i,
  input  logic [TAG_W-1:0]                       tag_i,
  input  logic [DATA_W-1:0]                      wdata_i,
  input  logic                                   rd_en,
  input  logic [$clog2(LINES)-1:0]               rd_line_i,
  input  logic [$clog2(WORDS)-1:0]               rd_word_i,
  output logic [DATA_W-1:0]                      rd_data_o,
  output logic [LINES-1:0][WORDS-1:0]            valid_o,
  output logic [LINES-1:0][WORDS-1:0][TAG_W-1:0] tags_o
);
  logic [LINES-1:0][WORDS-1:0]            valid_q;
  logic [LINES-1:0][WORDS-1:0][TAG_W-1:0] tags_q;
  logic [DATA_W-1:0]                      data_q [LINES][WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      tags_q  <= '0;
    end else if (alloc_en) begin
      if (alloc_evict) valid_q[line_i] <= '0;
      valid_q[line_i][word_i] <= 1'b1;
      tags_q[line_i][word_i]  <= tag_i;
    end
  end

  always_ff @(posedge clk) begin
    if (data_we) data_q[line_i][word_i] <= wdata_i;
  end

  // the data array is touched for reading only on a guaranteed hit
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data_o <= '0;
    else if (rd_en) rd_data_o <= data_q[rd_line_i][rd_word_i];
  end

  assign valid_o = valid_q;
  assign tags_o  = tags_q;

  assert_fill_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> valid_q[$past(line_i)][$past(word_i)]);

  assert_evict_single_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en && alloc_evict |=> $countones(valid_q[$past(line_i)]) == 1);
endmodule

// File: rtl/fc_lazy_filter_cache.sv
module fc_lazy_filter_cache
  import fc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CAP_BYTES  = 512,
  parameter int LINE_BYTES = 32,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spec_valid,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] spec_waddr,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  l1_req_valid,
  output logic                  l1_req_write,
  output logic [ADDR_W-1:0]     l1_req_addr,
  output logic [DATA_W-1:0]     l1_req_wdata,
  input  logic                  l1_rsp_valid,
  input  logic [DATA_W-1:0]     l1_rsp_rdata,
  output logic [CNT_W-1:0]      hit_count,
  output logic [CNT_W-1:0]      fill_count
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BOFF_W     = $clog2(WORD_BYTES);
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int LINES      = CAP_BYTES / LINE_BYTES;
  localparam int WOFF_W     = $clog2(WORDS);
  localparam int LINE_W     = $clog2(LINES);
  localparam int WADDR_W    = ADDR_W - BOFF_W;
  localparam int TAG_W      = WADDR_W - WOFF_W;

  function automatic logic [WADDR_W-1:0] word_addr_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BOFF_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [WADDR_W-1:0] w);
    return w[WADDR_W-1:WOFF_W];
  endfunction

  function automatic logic [WOFF_W-1:0] slot_of(input logic [WADDR_W-1:0] w);
    return w[WOFF_W-1:0];
  endfunction

  // state
  fc_state_e          state_q;
  logic               pend_write_q;
  logic [WADDR_W-1:0] pend_waddr_q;
  logic               sq_valid_q;
  logic               sq_hit_q;
  logic [LINE_W-1:0]  sq_line_q;
  logic [WADDR_W-1:0] sq_waddr_q;
  logic               rsp_valid_q;
  logic               rsp_from_l1_q;
  logic [DATA_W-1:0]  l1_data_q;
  logic [CNT_W-1:0]   hit_cnt_q;
  logic [CNT_W-1:0]   fill_cnt_q;

  // named internal events
  logic               busy;
  logic [WADDR_W-1:0] req_waddr;
  logic [WADDR_W-1:0] lk_waddr;
  logic               guaranteed_hit;
  logic               req_fire;
  logic               rd_hit_fire;
  logic               miss_fire;
  logic               upd_fire;
  logic               l1_done;
  logic               fill_fire;

  logic               spec_hit;
  logic [LINE_W-1:0]  spec_line;
  logic               act_hit;
  logic [LINE_W-1:0]  act_line;
  logic [LINE_W-1:0]  place_line;
  logic               place_evict;
  logic [LINE_W-1:0]  victim;
  logic [LINE_W-1:0]  touch_line;
  logic [LINE_W-1:0]  wr_line;
  logic [WOFF_W-1:0]  wr_slot;
  logic [DATA_W-1:0]  wr_data;
  logic [DATA_W-1:0]  store_rd;

  logic [LINES-1:0][WORDS-1:0]            valid_w;
  logic [LINES-1:0][WORDS-1:0][TAG_W-1:0] tags_w;

  assign busy           = (state_q == FC_WAIT);
  assign req_waddr      = word_addr_of(req_addr);
  assign lk_waddr       = busy ? pend_waddr_q : req_waddr;
  assign req_fire       = req_valid && !busy;
  assign guaranteed_hit = sq_valid_q && sq_hit_q && (sq_waddr_q == req_waddr);
  assign rd_hit_fire    = req_fire && !req_write && guaranteed_hit;
  assign miss_fire      = req_fire && !rd_hit_fire;
  assign upd_fire       = req_fire && req_write && act_hit;
  assign l1_done        = busy && l1_rsp_valid;
  assign fill_fire      = l1_done && !pend_write_q;

  // early tag search on the speculative address
  fc_word_lookup #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) spec_lookup_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag_i      (tag_of(spec_waddr)),
    .word_i     (slot_of(spec_waddr)),
    .valid_i    (valid_w),
    .tags_i     (tags_w),
    .hit_o      (spec_hit),
    .hit_line_o (spec_line)
  );

  // search on the committed address (store hits, fill placement)
  fc_word_lookup #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) act_lookup_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag_i      (tag_of(lk_waddr)),
    .word_i     (slot_of(lk_waddr)),
    .valid_i    (valid_w),
    .tags_i     (tags_w),
    .hit_o      (act_hit),
    .hit_line_o (act_line)
  );

  fc_fill_place #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) place_i (
    .tag_i      (tag_of(pend_waddr_q)),
    .word_i     (slot_of(pend_waddr_q)),
    .valid_i    (valid_w),
    .tags_i     (tags_w),
    .hit_i      (act_hit),
    .hit_line_i (act_line),
    .victim_i   (victim),
    .line_o     (place_line),
    .evict_o    (place_evict)
  );

  assign touch_line = rd_hit_fire ? sq_line_q : place_line;

  fc_lru #(.LINES(LINES)) lru_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .touch_i      (rd_hit_fire || fill_fire),
    .touch_line_i (touch_line),
    .victim_o     (victim)
  );

  assign wr_line = fill_fire ? place_line : act_line;
  assign wr_slot = fill_fire ? slot_of(pend_waddr_q) : slot_of(req_waddr);
  assign wr_data = fill_fire ? l1_rsp_rdata : req_wdata;

  fc_line_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_we     (fill_fire || upd_fire),
    .alloc_en    (fill_fire),
    .alloc_evict (place_evict),
    .line_i      (wr_line),
    .word_i      (wr_slot),
    .tag_i       (tag_of(pend_waddr_q)),
    .wdata_i     (wr_data),
    .rd_en       (rd_hit_fire),
    .rd_line_i   (sq_line_q),
    .rd_word_i   (slot_of(sq_waddr_q)),
    .rd_data_o   (store_rd),
    .valid_o     (valid_w),
    .tags_o      (tags_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= FC_IDLE;
      pend_write_q <= 1'b0;
      pend_waddr_q <= '0;
    end else if (!busy) begin
      if (miss_fire) begin
        state_q      <= FC_WAIT;
        pend_write_q <= req_write;
        pend_waddr_q <= req_waddr;
      end
    end else if (l1_rsp_valid) begin
      state_q <= FC_IDLE;
    end
  end

  // early result is dropped when a fill changes the arrays underneath it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_valid_q <= 1'b0;
      sq_hit_q   <= 1'b0;
      sq_line_q  <= '0;
      sq_waddr_q <= '0;
    end else begin
      sq_valid_q <= spec_valid && !fill_fire;
      sq_hit_q   <= spec_hit;
      sq_line_q  <= spec_line;
      sq_waddr_q <= spec_waddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q   <= 1'b0;
      rsp_from_l1_q <= 1'b0;
      l1_data_q     <= '0;
      hit_cnt_q     <= '0;
      fill_cnt_q    <= '0;
    end else begin
      rsp_valid_q   <= rd_hit_fire || l1_done;
      rsp_from_l1_q <= l1_done;
      if (l1_done) l1_data_q <= pend_write_q ? '0 : l1_rsp_rdata;
      if (rd_hit_fire) hit_cnt_q <= hit_cnt_q + 1'b1;
      if (fill_fire) fill_cnt_q <= fill_cnt_q + 1'b1;
    end
  end

  assign req_ready    = !busy;
  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rsp_from_l1_q ? l1_data_q : store_rd;
  assign l1_req_valid = miss_fire;
  assign l1_req_write = req_write;
  assign l1_req_addr  = req_addr;
  assign l1_req_wdata = req_wdata;
  assign hit_count    = hit_cnt_q;
  assign fill_count   = fill_cnt_q;

  assert_hit_next_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_fire |=> rsp_valid && req_ready);

  assert_hit_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_fire |=> hit_count == $past(hit_count) + 1'b1);

  assert_fill_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> fill_count == $past(fill_count) + 1'b1);

  assert_l1_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid |=> !req_ready);
endmodule

// File: tb/fc_lazy_filter_cache_tb.sv
module fc_lazy_filter_cache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spec_valid;
  logic [29:0] spec_waddr;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        l1_req_valid;
  logic        l1_req_write;
  logic [31:0] l1_req_addr;
  logic [31:0] l1_req_wdata;
  logic        l1_rsp_valid;
  logic [31:0] l1_rsp_rdata;
  logic [15:0] hit_count;
  logic [15:0] fill_count;

  int n_checks = 0;
  int n_fail   = 0;
  int l1_reads = 0;
  int l1_writes = 0;
  bit finished = 0;
  logic [31:0] mem [logic [31:0]];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fc_lazy_filter_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .spec_valid(spec_valid), .spec_waddr(spec_waddr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .l1_req_valid(l1_req_valid), .l1_req_write(l1_req_write),
    .l1_req_addr(l1_req_addr), .l1_req_wdata(l1_req_wdata),
    .l1_rsp_valid(l1_rsp_valid), .l1_rsp_rdata(l1_rsp_rdata),
    .hit_count(hit_count), .fill_count(fill_count)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] al = {a[31:2], 2'b00};
    if (mem.exists(al)) return mem[al];
    return {al[15:0] ^ 16'h5A5A, al[31:16] + 16'h0101};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // level-one model: one answer per request, one cycle after acceptance
  initial begin
    logic [31:0] a;
    logic [31:0] d;
    l1_rsp_valid = 1'b0;
    l1_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && l1_req_valid) begin
        a = {l1_req_addr[31:2], 2'b00};
        if (l1_req_write) begin
          mem[a] = l1_req_wdata;
          l1_writes++;
          d = '0;
        end else begin
          d = mem_rd(a);
          l1_reads++;
        end
        @(negedge clk);
        l1_rsp_valid = 1'b1;
        l1_rsp_rdata = d;
        @(negedge clk);
        l1_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 0);
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    spec_valid = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // spec_mode: 0 none, 1 same word as addr, 2 the word after addr
  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        input int spec_mode, output logic [31:0] rd, output int rd_d,
                        output int wr_d, output logic l1_now, output logic stalled);
    int r0 = l1_reads;
    int w0 = l1_writes;
    int guard = 0;
    @(negedge clk);
    if (spec_mode != 0) begin
      spec_valid = 1'b1;
      spec_waddr = (spec_mode == 1) ? addr[31:2] : addr[31:2] + 30'd1;
      @(negedge clk);
      spec_valid = 1'b0;
    end
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = wd;
    #1 l1_now = l1_req_valid;
    @(negedge clk);
    req_valid = 1'b0;
    stalled = !req_ready;
    while (!rsp_valid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 50) check(0, "R2", "no response", 0, 1);
    rd = rsp_rdata;
    rd_d = l1_reads - r0;
    wr_d = l1_writes - w0;
  endtask

  task automatic load_expect(input logic [31:0] addr, input int spec_mode,
                             input int exp_reads, input string req);
    logic [31:0] rd;
    int rd_d, wr_d;
    logic now, st;
    access(1'b0, addr, '0, spec_mode, rd, rd_d, wr_d, now, st);
    check(rd == mem_rd(addr), req, "load data", rd, mem_rd(addr));
    check(rd_d == exp_reads, req, "level-one reads", rd_d, exp_reads);
  endtask

  task automatic test_reset();
    do_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(hit_count == 0 && fill_count == 0, "R1", "counters after reset",
          {hit_count, fill_count}, 0);
    check(rsp_valid == 1'b0 && l1_req_valid == 1'b0, "R1", "idle outputs",
          {rsp_valid, l1_req_valid}, 0);
    load_expect(32'h0000_1000, 1, 1, "R1");
  endtask

  task automatic test_read_miss();
    logic [31:0] rd;
    int rd_d, wr_d;
    logic now, st;
    do_reset();
    access(1'b0, 32'h0000_2008, '0, 0, rd, rd_d, wr_d, now, st);
    check(rd == mem_rd(32'h0000_2008), "R2", "miss data", rd, mem_rd(32'h0000_2008));
    check(rd_d == 1, "R2", "single word read", rd_d, 1);
    check(now == 1'b1, "R6", "level-one request same cycle", now, 1);
    check(st == 1'b1, "R10", "not ready while waiting", st, 1);
    check(fill_count == 1, "R9", "fill count", fill_count, 1);
  endtask

  task automatic test_spec_hit();
    logic [31:0] rd;
    int rd_d, wr_d;
    logic now, st;
    access(1'b0, 32'h0000_2008, '0, 1, rd, rd_d, wr_d, now, st);
    check(rd == mem_rd(32'h0000_2008), "R5", "hit data", rd, mem_rd(32'h0000_2008));
    check(rd_d == 0 && now == 1'b0, "R5", "no level-one read on hit", rd_d, 0);
    check(st == 1'b0, "R5", "answered next cycle", st, 0);
    check(hit_count == 1, "R9", "hit count", hit_count, 1);
    load_expect(32'h0000_2008, 2, 1, "R6");
    load_expect(32'h0000_2008, 0, 1, "R6");
    check(hit_count == 1, "R9", "no hit counted off early path", hit_count, 1);
  endtask

  task automatic test_word_miss();
    do_reset();
    load_expect(32'h0000_3000, 0, 1, "R3");
    load_expect(32'h0000_3004, 1, 1, "R3");
    load_expect(32'h0000_3000, 1, 0, "R3");
    load_expect(32'h0000_3004, 1, 0, "R3");
  endtask

  task automatic test_store();
    logic [31:0] rd;
    int rd_d, wr_d;
    logic now, st;
    do_reset();
    load_expect(32'h0000_4010, 0, 1, "R7");
    access(1'b1, 32'h0000_4010, 32'hDEAD_BEEF, 0, rd, rd_d, wr_d, now, st);
    check(wr_d == 1 && now == 1'b1, "R7", "store written through", wr_d, 1);
    load_expect(32'h0000_4010, 1, 0, "R7");
    check(mem_rd(32'h0000_4010) == 32'hDEAD_BEEF, "R7", "store value seen",
          mem_rd(32'h0000_4010), 32'hDEAD_BEEF);
    access(1'b1, 32'h0000_5020, 32'h1234_5678, 1, rd, rd_d, wr_d, now, st);
    check(wr_d == 1, "R7", "store miss written through", wr_d, 1);
    load_expect(32'h0000_5020, 1, 1, "R7");
  endtask

  task automatic test_packing();
    do_reset();
    for (int i = 0; i < 16; i++) load_expect(32'h0001_0000 + i * 32'h40, 0, 1, "R4");
    load_expect(32'h0002_0004, 0, 1, "R4");
    for (int i = 0; i < 16; i++) load_expect(32'h0001_0000 + i * 32'h40, 1, 0, "R4");
    load_expect(32'h0002_0004, 1, 0, "R4");
    check(hit_count == 17, "R9", "hits after packing", hit_count, 17);
    check(fill_count == 17, "R9", "fills after packing", fill_count, 17);
  endtask

  task automatic test_lru();
    do_reset();
    for (int i = 0; i < 16; i++) load_expect(32'h0006_0000 + i * 32'h40, 0, 1, "R8");
    load_expect(32'h0006_0000, 1, 0, "R8");
    load_expect(32'h0006_0400, 0, 1, "R8");
    load_expect(32'h0006_0000, 1, 0, "R8");
    load_expect(32'h0006_0400, 1, 0, "R8");
    load_expect(32'h0006_0080, 1, 0, "R8");
    load_expect(32'h0006_0040, 1, 1, "R8");
  endtask

  task automatic test_evict_clear();
    do_reset();
    load_expect(32'h0004_0000, 0, 1, "R8");
    load_expect(32'h0004_0004, 0, 1, "R8");
    load_expect(32'h0004_0004, 1, 0, "R8");
    for (int i = 1; i < 17; i++) load_expect(32'h0003_0000 + i * 32'h40, 0, 1, "R8");
    load_expect(32'h0004_0004, 1, 1, "R8");
  endtask

  initial begin
    rst_n = 1'b0;
    spec_valid = 1'b0;
    spec_waddr = '0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    test_reset();
    test_read_miss();
    test_spec_hit();
    test_word_miss();
    test_store();
    test_packing();
    test_lru();
    test_evict_clear();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule